// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial bit stream. A CPU-side write port fills a one-character holding register; the character then moves into a shift register, which frames it and sends it on a line that idles high. Because the two registers are separate, software can queue the next character while the current one is still on the wire. Back-to-back characters then leave with no idle gap between them.

Two status flags show where characters are in the pipeline. The holding-empty flag tells software when it may write again. The transmitter-empty flag tells it when the line has gone fully quiet. All timing runs from a clock-enable pulse at sixteen times the bit rate, and the character format comes from a small set of line-control inputs. These inputs set the word length, the stop-bit count and parity. They are sampled when a character enters the shift register.

Top module: `uart_tx_core`

## Requirements
- R1: After reset and whenever nothing is queued or shifting, `txd_o` is 1, `thre_o` is 1 and `temt_o` is 1.
- R2: A cycle with `wr_i` high makes `thre_o` and `temt_o` read 0 from the next clock edge.
- R3: On the first `tick_i` that finds the holding register full and the shifter idle, the character moves to the shifter. From the next edge, `txd_o` drives the start bit (0), `thre_o` is 1 and `temt_o` is 0.
- R4: A frame is a start bit of 0, then the data bits least significant first. `word_len_i` selects the count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the word length are not sent, and every bit lasts 16 ticks.
- R5: With `par_en_i` = 1, a parity bit follows the last data bit and precedes the first stop bit. `par_even_i` = 1 makes the count of ones in data plus parity even; 0 makes it odd.
- R6: Stop bits are 1. With `stop_long_i` = 0 there is one stop bit. With `stop_long_i` = 1 there are 1.5 stop bits (24 ticks) for 5-bit words and 2 stop bits for 6 to 8 bit words.
- R7: `temt_o` stays 0 for every tick of the character. It returns to 1 on the tick that ends the last stop bit if no character is pending.
- R8: A character written while the shifter is busy waits in the holding register and `thre_o` stays 0. It is loaded on the tick that ends the previous stop bit, so its start bit follows with no idle time.
- R9: A write while `thre_o` is 0 replaces the pending character and leaves the character being shifted unchanged.
- R10: Line-control inputs are sampled only at the transfer into the shifter. Changing them mid-character has no effect on that character.
- R11: Without `tick_i`, `txd_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Enable pulse at 16x the bit rate |
| wr_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Character to send |
| word_len_i | input | 2 | Data bits minus 5 |
| stop_long_i | input | 1 | Longer stop period (1.5 or 2 bits) |
| par_en_i | input | 1 | Parity bit enable |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| txd_o | output | 1 | Serial line, idles high |
| thre_o | output | 1 | Holding register empty |
| temt_o | output | 1 | Holding and shift registers both empty |

## Verification
The bench sends a set of characters covering every word length, with no parity, even parity and odd parity, and both stop settings. These include all-zero and all-one data, so a swapped bit order, a wrong parity sense, a wrong frame length or a leaked upper bit each changes the line at a known tick.

The 5-bit characters with the long stop setting separate 1.5 from 2 stop bits, because `temt_o` must rise exactly eight ticks earlier. A write, two more writes while the shifter is busy, and an immediate follow-on frame tell apart a gap between characters, a lost or corrupted character, and a wrong pending one. Changing the line-control inputs mid-character and pausing the tick mid-bit expose sampling at the wrong time and enable gating errors.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int MIN_WORD = 5;

  typedef struct packed {
    logic       par_even;
    logic       par_en;
    logic       stop_long;
    logic [1:0] word_len;
  } tx_cfg_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;

  // a write on a load cycle: shifter takes the old value, new one stays pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (wr_i) data_q <= wr_data_i;
      if (wr_i)        full_q <= 1'b1;
      else if (load_i) full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  p_wr_sets_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> full_o);
  p_load_needs_full_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> full_o);
  p_overwrite_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (data_o == $past(wr_data_i)));
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  tx_cfg_t            cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o,
  output logic               half_stop_o
);
  int                nb;
  logic [DATA_W-1:0] mask;
  logic              par_bit;

  always_comb begin
    nb = MIN_WORD + int'(cfg_i.word_len);
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < nb);
    par_bit = ^(data_i & mask);
    if (!cfg_i.par_even) par_bit = ~par_bit;

    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < nb) frame_o[i+1] = data_i[i];
    for (int p = 1; p < FRAME_W; p++)
      if (cfg_i.par_en && p == nb + 1) frame_o[p] = par_bit;

    nbits_o = CNT_W'(1 + nb + (cfg_i.par_en ? 1 : 0) + (cfg_i.stop_long ? 2 : 1));
    half_stop_o = cfg_i.stop_long && (cfg_i.word_len == 2'd0);
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W + 1),
  parameter int OVS     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               pend_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   nbits_i,
  input  logic               half_i,
  output logic               load_o,
  output logic               busy_o,
  output logic               txd_o
);
  localparam int SUB_W = $clog2(OVS);
  localparam logic [SUB_W-1:0] BIT_END  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] HALF_END = SUB_W'(OVS / 2 - 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [SUB_W-1:0]   sub_q;
  logic               busy_q, half_q;
  logic               last_bit, bit_end, ready;

  assign last_bit = (left_q == CNT_W'(1));
  assign bit_end  = busy_q && tick_i && (sub_q == ((last_bit && half_q) ? HALF_END : BIT_END));
  assign ready    = !busy_q || (bit_end && last_bit);
  assign load_o   = tick_i && pend_i && ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      busy_q <= 1'b0;
      half_q <= 1'b0;
    end else if (load_o) begin
      sh_q   <= frame_i;
      left_q <= nbits_i;
      sub_q  <= '0;
      busy_q <= 1'b1;
      half_q <= half_i;
    end else if (busy_q && tick_i) begin
      if (bit_end) begin
        sub_q <= '0;
        if (last_bit) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - CNT_W'(1);
        end
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  p_start_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !txd_o);
  p_stop_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last_bit) |-> txd_o);
  p_txd_gated_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(txd_o));
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        word_len_i,
  input  logic              stop_long_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  output logic              txd_o,
  output logic              thre_o,
  output logic              temt_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  tx_cfg_t            cfg;
  logic [DATA_W-1:0]  hold_data;
  logic               hold_full, load, busy, half_stop;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  assign cfg = '{par_even: par_even_i, par_en: par_en_i, stop_long: stop_long_i,
                 word_len: word_len_i};

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .wr_i, .wr_data_i,
    .load_i (load),
    .data_o (hold_data),
    .full_o (hold_full)
  );

  uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_framer (
    .data_i      (hold_data),
    .cfg_i       (cfg),
    .frame_o     (frame),
    .nbits_o     (nbits),
    .half_stop_o (half_stop)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W), .OVS(OVS)) u_shift (
    .clk_i, .rst_ni, .tick_i,
    .pend_i  (hold_full),
    .frame_i (frame),
    .nbits_i (nbits),
    .half_i  (half_stop),
    .load_o  (load),
    .busy_o  (busy),
    .txd_o   (txd_o)
  );

  assign thre_o = !hold_full;
  assign temt_o = !hold_full && !busy;

  p_idle_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temt_o |-> txd_o);
  p_wr_clears_thre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (!thre_o && !temt_o));
  p_load_frees_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !wr_i) |=> (thre_o && !temt_o));
  p_temt_implies_thre_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    temt_o |-> thre_o);
endmodule

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [4:0] cfg = '0; // {par_even, par_en, stop_long, word_len[1:0]}
  logic       txd, thre, temt;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  uart_tx_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_i(wr), .wr_data_i(wdata),
    .word_len_i(cfg[1:0]), .stop_long_i(cfg[2]), .par_en_i(cfg[3]), .par_even_i(cfg[4]),
    .txd_o(txd), .thre_o(thre), .temt_o(temt)
  );

  localparam logic [12:0] VEC [8] = '{
    {5'b00011, 8'h55}, {5'b11011, 8'hA7}, {5'b01010, 8'h3C}, {5'b00101, 8'h2D},
    {5'b00100, 8'h13}, {5'b01100, 8'h1F}, {5'b01111, 8'h00}, {5'b11010, 8'hFF}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic exp_slot(input logic [4:0] c, input logic [7:0] d, input int j);
    logic b [12];
    logic p;
    int   nb = 5 + int'(c[1:0]);
    p = 1'b0;
    for (int i = 0; i < 12; i++) b[i] = 1'b1;
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) if (i < nb) begin b[1+i] = d[i]; p ^= d[i]; end
    if (c[3]) b[1+nb] = c[4] ? p : ~p;
    return (j / 16 < 12) ? b[j/16] : 1'b1;
  endfunction

  function automatic int frame_ticks(input logic [4:0] c);
    int nb = 5 + int'(c[1:0]);
    int nbits = 1 + nb + (c[3] ? 1 : 0) + (c[2] ? 2 : 1);
    return 16 * nbits - ((c[2] && nb == 5) ? 8 : 0);
  endfunction

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk) begin wr = 1'b1; wdata = d; end
    @(negedge clk) wr = 1'b0;
  endtask

  task automatic run_frame(input logic [4:0] c, input logic [7:0] d, input int s0,
                           input logic exp_thre, input string req);
    int t = frame_ticks(c);
    int bad = -1;
    bit temt_bad = 0, thre_bad = 0;
    for (int j = s0; j < t; j++) begin
      do_tick();
      if (txd !== exp_slot(c, d, j) && bad < 0) bad = j;
      if (temt !== 1'b0) temt_bad = 1;
      if (thre !== exp_thre) thre_bad = 1;
    end
    check(bad < 0, req, "first wrong tick slot", bad, -1);
    check(!temt_bad, "R7", "temt_o high inside character", int'(temt_bad), 0);
    check(!thre_bad, "R8", "thre_o wrong inside character", int'(!exp_thre), int'(exp_thre));
  endtask

  task automatic finish_idle(input string req);
    do_tick();
    check(txd === 1'b1 && thre === 1'b1 && temt === 1'b1, req, "idle {txd,thre,temt}",
          int'({txd, thre, temt}), 7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic sv;
    repeat (3) @(negedge clk);
    check(txd === 1'b1 && thre === 1'b1 && temt === 1'b1, "R1", "reset {txd,thre,temt}",
          int'({txd, thre, temt}), 7);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: formats, parity, stop lengths
    foreach (VEC[v]) begin
      cfg = VEC[v][12:8];
      do_write(VEC[v][7:0]);
      check(thre === 1'b0 && temt === 1'b0, "R2", "after write {thre,temt}",
            int'({thre, temt}), 0);
      run_frame(VEC[v][12:8], VEC[v][7:0], 0, 1'b1, "R4 R5 R6");
      finish_idle("R7 R6");
    end

    // R3 transfer, R9 overwrite, R8 back-to-back
    cfg = 5'b00011;
    do_write(8'h11);
    do_tick();
    check(txd === 1'b0 && thre === 1'b1 && temt === 1'b0, "R3", "load {txd,thre,temt}",
          int'({txd, thre, temt}), 2);
    do_write(8'h22);
    do_write(8'h33);
    check(thre === 1'b0, "R9", "thre_o with pending", int'(thre), 0);
    run_frame(cfg, 8'h11, 1, 1'b0, "R9 shifting char");
    run_frame(cfg, 8'h33, 0, 1'b1, "R8 R9 pending char");
    finish_idle("R8");

    // R10: format change mid-character is ignored
    cfg = 5'b00011;
    do_write(8'h96);
    do_tick();
    cfg = 5'b11100;
    run_frame(5'b00011, 8'h96, 1, 1'b1, "R10");
    finish_idle("R10");

    // R11: no tick, no movement
    cfg = 5'b00011;
    do_write(8'h01);
    for (int k = 0; k < 16; k++) do_tick();
    sv = txd;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (txd !== sv) sv = 1'bx;
    end
    check(sv === 1'b0, "R11", "txd_o held without tick", int'(txd), 0);
    run_frame(5'b00011, 8'h01, 16, 1'b1, "R11");
    finish_idle("R11");

    summary();
    $finish;
  end
endmodule